// File: doc/BRIEF.md
# Selective-Storage Trace Fill Unit

This block builds trace descriptors from a stream of basic blocks and keeps the useful ones in a small direct-mapped trace store. Each incoming block gives its start address, its instruction count, how it ends and where control goes next. The fetch stage or the commit stage can drive this stream. The unit joins consecutive blocks into one open trace. It closes that trace on a length cap, on a branch-count cap, or at an indirect jump or return.

A closed trace is stored only if at least one of its branches was taken. A trace that ran straight through can already be supplied by the instruction cache in one access, so storing it would waste a line. Stored lines are indexed by the low bits of the start address. A lookup with a fetch address and a vector of predicted outcomes hits only when the tag matches and the predictions agree with the stored outcomes for the branches the trace holds. A flush input empties the whole store in one cycle.

All addresses are instruction word addresses, so the address after a block is its start plus its length.

Top module: `tfill_unit`

## Requirements
- R1: After reset every line is invalid, and every lookup misses.
- R2: An open trace closes as soon as its summed instruction count is at least MAX_INSNS. The last block is kept whole, and the recorded length is the full sum.
- R3: An open trace closes when it holds MAX_BR branches, and the next block starts a new trace.
- R4: An open trace closes after any block whose end code is 3 (indirect jump or return), whatever its length or branch count.
- R5: A closed trace with no taken outcome is discarded, and the line at its index keeps its previous contents.
- R6: A closed trace with a taken outcome is written at index start[log2(ENTRIES)-1:0]. A hit returns:
  - the trace length;
  - the branch count;
  - the fall-through address, equal to the last block's start plus its length;
  - the last block's next address.

  A miss drives all four result fields to zero.
- R7: A lookup hits only if the line is valid, the upper address bits match, and predicted bit i equals stored outcome i for every i below the stored branch count. Predicted bits at or above the count are ignored.
- R8: A stored trace replaces any line at the same index with a different tag, and lines at other indexes are not affected.
- R9: A flush invalidates every line at the clock edge. A trace that closes in the same cycle is dropped, and a trace still open is kept and keeps growing.
- R10: A written trace can be found by lookup from the cycle after its closing block is presented. During the closing cycle itself the lookup still misses.
- R11: End codes:
  - 0: the block ends without a branch and adds no branch.
  - 1: conditional branch, with outcome bb_taken.
  - 2: direct jump, counted as taken.
  - 3: indirect jump or return, counted as taken.

  Outcome bit i of a trace is the outcome of its i-th branch in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all stored traces |
| bb_valid | input | 1 | A basic block is presented this cycle |
| bb_pc | input | PC_W | Start word address of the block |
| bb_len | input | BLEN_W | Instructions in the block, 1 to MAX_INSNS |
| bb_kind | input | 2 | End code of the block (see R11) |
| bb_taken | input | 1 | Outcome of an ending conditional branch |
| bb_next | input | PC_W | Address control reaches after the block |
| lk_pc | input | PC_W | Fetch address to look up |
| lk_pred | input | MAX_BR | Predicted outcomes, bit i for branch i |
| lk_hit | output | 1 | Lookup hit |
| lk_len | output | TLEN_W | Length of the hit trace |
| lk_nbr | output | NBR_W | Branch count of the hit trace |
| lk_next | output | PC_W | Next fetch address after the hit trace |
| lk_fall | output | PC_W | Fall-through address of the hit trace's last block |

## Verification
The bench builds the unit with 16-bit addresses, eight lines, a length cap of eight instructions and a cap of three branches. With only eight lines, index aliasing and replacement happen within a few blocks. The short length cap lets two blocks overshoot the limit. Three branches fit inside a trace that is shorter than the length cap, so each closing rule can be reached on its own. The random phase draws addresses from a pool of 32 words, so lookups often reach lines that were just written and also test tag mismatches and prediction mismatches.

// File: rtl/tfill_pkg.sv
// Shared definitions for the trace fill unit.
// Assumes: a basic block ends in exactly one of the listed ways.
package tfill_pkg;

    // How a basic block ends; only BK_NONE adds no branch to a trace.
    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_COND = 2'd1,
        BK_JUMP = 2'd2,
        BK_IND  = 2'd3
    } blk_end_e;

endpackage

// File: rtl/tfill_builder.sv
// Trace assembler: merges incoming basic blocks into one open trace and
// emits a closed trace descriptor in the same cycle as the closing block.
// Assumes: in_len is between 1 and MAX_INSNS; at most one block per cycle.
module tfill_builder
    import tfill_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int MAX_INSNS = 16,
    parameter int MAX_BR    = 3,
    parameter int BLEN_W    = 5,
    parameter int TLEN_W    = 5,
    parameter int NBR_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [BLEN_W-1:0] in_len,
    input  blk_end_e          in_kind,
    input  logic              in_taken,
    input  logic [PC_W-1:0]   in_next,
    output logic              emit,
    output logic              emit_red,
    output logic [PC_W-1:0]   emit_start,
    output logic [TLEN_W-1:0] emit_len,
    output logic [NBR_W-1:0]  emit_nbr,
    output logic [MAX_BR-1:0] emit_mask,
    output logic [PC_W-1:0]   emit_fall,
    output logic [PC_W-1:0]   emit_next,
    output logic              open_active,
    output logic [TLEN_W-1:0] open_len,
    output logic [NBR_W-1:0]  open_nbr
);

    logic              open_q;
    logic [PC_W-1:0]   start_q;
    logic [TLEN_W-1:0] len_q;
    logic [NBR_W-1:0]  nbr_q;
    logic [MAX_BR-1:0] mask_q;
    logic              red_q;

    logic              is_br;
    logic              tk;
    logic [PC_W-1:0]   cur_start;
    logic [TLEN_W-1:0] base_len;
    logic [NBR_W-1:0]  base_nbr;
    logic [MAX_BR-1:0] base_mask;
    logic [TLEN_W-1:0] new_len;
    logic [NBR_W-1:0]  new_nbr;
    logic [MAX_BR-1:0] new_mask;
    logic              new_red;
    logic              close;

    // Extend the open trace (or a fresh one) with the incoming block.
    always_comb begin
        base_len  = open_q ? len_q  : '0;
        base_nbr  = open_q ? nbr_q  : '0;
        base_mask = open_q ? mask_q : '0;
        cur_start = open_q ? start_q : in_pc;
        is_br     = (in_kind != BK_NONE);
        tk        = (in_kind == BK_COND) ? in_taken : is_br;
        new_len   = base_len + TLEN_W'(in_len);
        new_nbr   = base_nbr + NBR_W'(is_br);
        new_mask  = base_mask;
        for (int i = 0; i < MAX_BR; i++) begin
            if (is_br && (base_nbr == NBR_W'(i))) new_mask[i] = tk;
        end
        new_red   = (open_q && red_q) || tk;
        close     = in_valid && ((new_len >= TLEN_W'(MAX_INSNS)) ||
                                 (new_nbr == NBR_W'(MAX_BR)) ||
                                 (in_kind == BK_IND));
    end

    // Hold the open trace between blocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else if (in_valid) begin
            open_q  <= !close;
            start_q <= cur_start;
            len_q   <= new_len;
            nbr_q   <= new_nbr;
            mask_q  <= new_mask;
            red_q   <= new_red;
        end
    end

    // Present the closed descriptor to the storage decision.
    always_comb begin
        emit       = close;
        emit_red   = new_red;
        emit_start = cur_start;
        emit_len   = new_len;
        emit_nbr   = new_nbr;
        emit_mask  = new_mask;
        emit_fall  = in_pc + PC_W'(in_len);
        emit_next  = in_next;
    end

    // Expose the open-trace state for checking.
    assign open_active = open_q;
    assign open_len    = open_q ? len_q : '0;
    assign open_nbr    = open_q ? nbr_q : '0;

endmodule

// File: rtl/tfill_store.sv
// Direct-mapped trace store: one write port, one combinational lookup.
// Assumes: ENTRIES is a power of two; a clear takes priority over a write.
module tfill_store #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 64,
    parameter int MAX_BR  = 3,
    parameter int TLEN_W  = 5,
    parameter int NBR_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_start,
    input  logic [TLEN_W-1:0] wr_len,
    input  logic [NBR_W-1:0]  wr_nbr,
    input  logic [MAX_BR-1:0] wr_mask,
    input  logic [PC_W-1:0]   wr_fall,
    input  logic [PC_W-1:0]   wr_next,
    input  logic [PC_W-1:0]   rd_pc,
    input  logic [MAX_BR-1:0] rd_pred,
    output logic              rd_hit,
    output logic [TLEN_W-1:0] rd_len,
    output logic [NBR_W-1:0]  rd_nbr,
    output logic [PC_W-1:0]   rd_next,
    output logic [PC_W-1:0]   rd_fall
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [TLEN_W-1:0]  len_q  [ENTRIES];
    logic [NBR_W-1:0]   nbr_q  [ENTRIES];
    logic [MAX_BR-1:0]  mask_q [ENTRIES];
    logic [PC_W-1:0]    fall_q [ENTRIES];
    logic [PC_W-1:0]    next_q [ENTRIES];

    logic [IDX_W-1:0]   widx;
    logic [IDX_W-1:0]   ridx;
    logic [MAX_BR-1:0]  br_ok;

    assign widx = wr_start[IDX_W-1:0];
    assign ridx = rd_pc[IDX_W-1:0];

    // Valid bits: reset and clear empty the store, a write fills one line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (clr) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[widx] <= 1'b1;
        end
    end

    // Line payload; a cleared cycle writes nothing.
    always_ff @(posedge clk) begin
        if (wr_en && !clr) begin
            tag_q[widx]  <= wr_start[PC_W-1:IDX_W];
            len_q[widx]  <= wr_len;
            nbr_q[widx]  <= wr_nbr;
            mask_q[widx] <= wr_mask;
            fall_q[widx] <= wr_fall;
            next_q[widx] <= wr_next;
        end
    end

    // One compare per branch slot; slots past the stored count always agree.
    for (genvar g = 0; g < MAX_BR; g++) begin : g_slot
        assign br_ok[g] = (nbr_q[ridx] <= NBR_W'(g)) ||
                          (rd_pred[g] == mask_q[ridx][g]);
    end

    // Hit decision and zeroed results on a miss.
    always_comb begin
        rd_hit  = valid_q[ridx] && (tag_q[ridx] == rd_pc[PC_W-1:IDX_W]) && (&br_ok);
        rd_len  = rd_hit ? len_q[ridx]  : '0;
        rd_nbr  = rd_hit ? nbr_q[ridx]  : '0;
        rd_next = rd_hit ? next_q[ridx] : '0;
        rd_fall = rd_hit ? fall_q[ridx] : '0;
    end

endmodule

// File: rtl/tfill_unit.sv
// Top of the trace fill unit: the assembler feeds a storage filter that
// keeps only traces with a taken branch, in a direct-mapped store.
// Assumes: word addresses; ENTRIES a power of two; MAX_BR < 2**NBR_W.
module tfill_unit
    import tfill_pkg::*;
#(
    parameter  int PC_W      = 32,
    parameter  int ENTRIES   = 64,
    parameter  int MAX_INSNS = 16,
    parameter  int MAX_BR    = 3,
    localparam int BLEN_W    = $clog2(MAX_INSNS + 1),
    localparam int TLEN_W    = $clog2(2 * MAX_INSNS),
    localparam int NBR_W     = $clog2(MAX_BR + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              bb_valid,
    input  logic [PC_W-1:0]   bb_pc,
    input  logic [BLEN_W-1:0] bb_len,
    input  logic [1:0]        bb_kind,
    input  logic              bb_taken,
    input  logic [PC_W-1:0]   bb_next,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [MAX_BR-1:0] lk_pred,
    output logic              lk_hit,
    output logic [TLEN_W-1:0] lk_len,
    output logic [NBR_W-1:0]  lk_nbr,
    output logic [PC_W-1:0]   lk_next,
    output logic [PC_W-1:0]   lk_fall
);

    logic              emit;
    logic              emit_red;
    logic [PC_W-1:0]   emit_start;
    logic [TLEN_W-1:0] emit_len;
    logic [NBR_W-1:0]  emit_nbr;
    logic [MAX_BR-1:0] emit_mask;
    logic [PC_W-1:0]   emit_fall;
    logic [PC_W-1:0]   emit_next;
    logic              open_active;
    logic [TLEN_W-1:0] open_len;
    logic [NBR_W-1:0]  open_nbr;
    logic              keep;

    tfill_builder #(
        .PC_W(PC_W), .MAX_INSNS(MAX_INSNS), .MAX_BR(MAX_BR),
        .BLEN_W(BLEN_W), .TLEN_W(TLEN_W), .NBR_W(NBR_W)
    ) i_builder (
        .clk(clk), .rst_n(rst_n),
        .in_valid(bb_valid), .in_pc(bb_pc), .in_len(bb_len),
        .in_kind(blk_end_e'(bb_kind)), .in_taken(bb_taken), .in_next(bb_next),
        .emit(emit), .emit_red(emit_red), .emit_start(emit_start),
        .emit_len(emit_len), .emit_nbr(emit_nbr), .emit_mask(emit_mask),
        .emit_fall(emit_fall), .emit_next(emit_next),
        .open_active(open_active), .open_len(open_len), .open_nbr(open_nbr)
    );

    // Storage filter: straight-line traces are dropped here.
    assign keep = emit && emit_red;

    tfill_store #(
        .PC_W(PC_W), .ENTRIES(ENTRIES), .MAX_BR(MAX_BR),
        .TLEN_W(TLEN_W), .NBR_W(NBR_W)
    ) i_store (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .wr_en(keep), .wr_start(emit_start), .wr_len(emit_len),
        .wr_nbr(emit_nbr), .wr_mask(emit_mask), .wr_fall(emit_fall),
        .wr_next(emit_next),
        .rd_pc(lk_pc), .rd_pred(lk_pred), .rd_hit(lk_hit), .rd_len(lk_len),
        .rd_nbr(lk_nbr), .rd_next(lk_next), .rd_fall(lk_fall)
    );

endmodule

// File: rtl/tfill_unit_chk.sv
// Property checker for the trace fill unit, bound to every instance.
// Assumes: reset is asserted from time zero.
module tfill_unit_chk #(
    parameter int MAX_INSNS = 16,
    parameter int MAX_BR    = 3,
    parameter int BLEN_W    = 5,
    parameter int TLEN_W    = 5,
    parameter int NBR_W     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              bb_valid,
    input logic [BLEN_W-1:0] bb_len,
    input logic [1:0]        bb_kind,
    input logic              lk_hit,
    input logic [TLEN_W-1:0] lk_len,
    input logic [NBR_W-1:0]  lk_nbr,
    input logic              open_active,
    input logic [TLEN_W-1:0] open_len,
    input logic [NBR_W-1:0]  open_nbr
);

    // R1: first cycle out of reset sees an empty store.
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !lk_hit);

    // R9: the cycle after a flush nothing can hit.
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R6: any stored trace has at least one instruction and one branch.
    a_r6_hit_has_taken: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((lk_nbr != '0) && (lk_len != '0)));

    // R3: an open trace never holds the full branch budget.
    a_r3_branch_cap: assert property (@(posedge clk) disable iff (!rst_n)
        open_active |-> (int'(open_nbr) < MAX_BR));

    // R4: an indirect ending leaves no trace open.
    a_r4_indirect_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_valid && (bb_kind == 2'd3)) |=> !open_active);

    // R2: reaching the length cap leaves no trace open.
    a_r2_length_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (bb_valid && ((int'(open_len) + int'(bb_len)) >= MAX_INSNS)) |=> !open_active);

endmodule

bind tfill_unit tfill_unit_chk #(
    .MAX_INSNS(MAX_INSNS), .MAX_BR(MAX_BR),
    .BLEN_W(BLEN_W), .TLEN_W(TLEN_W), .NBR_W(NBR_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .bb_valid(bb_valid),
    .bb_len(bb_len), .bb_kind(bb_kind), .lk_hit(lk_hit), .lk_len(lk_len),
    .lk_nbr(lk_nbr), .open_active(open_active), .open_len(open_len),
    .open_nbr(open_nbr)
);

// File: tb/test_tfill_unit.sv
// Bench: behavioural reference model compared on every clock, plus
// directed probes with hand-computed expectations.
module test_tfill_unit;

    localparam int PCW = 16;
    localparam int E   = 8;
    localparam int MI  = 8;
    localparam int MB  = 3;
    localparam int BLW = $clog2(MI + 1);
    localparam int TLW = $clog2(2 * MI);
    localparam int NBW = $clog2(MB + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           flush = 1'b0;
    logic           bb_valid = 1'b0;
    logic [PCW-1:0] bb_pc = '0;
    logic [BLW-1:0] bb_len = '0;
    logic [1:0]     bb_kind = '0;
    logic           bb_taken = 1'b0;
    logic [PCW-1:0] bb_next = '0;
    logic [PCW-1:0] lk_pc = '0;
    logic [MB-1:0]  lk_pred = '0;
    logic           lk_hit;
    logic [TLW-1:0] lk_len;
    logic [NBW-1:0] lk_nbr;
    logic [PCW-1:0] lk_next;
    logic [PCW-1:0] lk_fall;

    int checks = 0;
    int fails  = 0;
    bit cmp_en = 0;

    always #5 clk = ~clk;

    tfill_unit #(.PC_W(PCW), .ENTRIES(E), .MAX_INSNS(MI), .MAX_BR(MB)) i_tfill_unit (
        .clk(clk), .rst_n(rst_n), .flush(flush), .bb_valid(bb_valid),
        .bb_pc(bb_pc), .bb_len(bb_len), .bb_kind(bb_kind), .bb_taken(bb_taken),
        .bb_next(bb_next), .lk_pc(lk_pc), .lk_pred(lk_pred), .lk_hit(lk_hit),
        .lk_len(lk_len), .lk_nbr(lk_nbr), .lk_next(lk_next), .lk_fall(lk_fall)
    );

    // Reference model state
    int m_open, m_start, m_len, m_nbr, m_mask, m_red;
    int mv[E], ms[E], ml[E], mn[E], mm[E], mf[E], mx[E];

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Advance the model by one clock edge using the values presented.
    task automatic model_edge();
        int wr, tk, isbr, idx;
        wr = 0;
        if (!rst_n) begin
            m_open = 0;
            for (int i = 0; i < E; i++) mv[i] = 0;
            return;
        end
        if (bb_valid) begin
            if (m_open == 0) begin
                m_start = bb_pc; m_len = 0; m_nbr = 0; m_mask = 0; m_red = 0;
            end
            m_len += bb_len;
            isbr = (bb_kind != 0);
            tk = (bb_kind == 1) ? bb_taken : isbr;
            if (isbr) begin
                if (tk) m_mask |= (1 << m_nbr);
                m_nbr++;
            end
            if (tk) m_red = 1;
            if (m_len >= MI || m_nbr == MB || bb_kind == 3) begin
                m_open = 0;
                wr = m_red;
            end else begin
                m_open = 1;
            end
        end
        if (flush) begin
            for (int i = 0; i < E; i++) mv[i] = 0;
        end else if (wr) begin
            idx = m_start % E;
            mv[idx] = 1; ms[idx] = m_start; ml[idx] = m_len; mn[idx] = m_nbr;
            mm[idx] = m_mask; mf[idx] = (bb_pc + bb_len) & 16'hFFFF; mx[idx] = bb_next;
        end
    endtask

    // Compare the lookup against the model, clock once, clear one-shot inputs.
    task automatic tick();
        int idx, eh;
        #1;
        if (cmp_en) begin
            idx = lk_pc % E;
            eh = mv[idx] && (ms[idx] == lk_pc);
            for (int i = 0; i < MB; i++)
                if (eh && i < mn[idx] && lk_pred[i] != mm[idx][i]) eh = 0;
            chk("R7", "model hit", 32'(lk_hit), 32'(eh));
            chk("R6", "model len", 32'(lk_len), eh ? 32'(ml[idx]) : 0);
            chk("R6", "model nbr", 32'(lk_nbr), eh ? 32'(mn[idx]) : 0);
            chk("R6", "model next", 32'(lk_next), eh ? 32'(mx[idx]) : 0);
            chk("R6", "model fall", 32'(lk_fall), eh ? 32'(mf[idx]) : 0);
        end
        @(posedge clk);
        model_edge();
        @(negedge clk);
        bb_valid = 0;
        flush = 0;
    endtask

    task automatic blk(int pc, int len, int kind, int tk, int nxt);
        bb_valid = 1; bb_pc = PCW'(pc); bb_len = BLW'(len);
        bb_kind = 2'(kind); bb_taken = 1'(tk); bb_next = PCW'(nxt);
        tick();
    endtask

    task automatic probe(string tag, int pc, int pred, int eh, int el, int en, int ex, int ef);
        lk_pc = PCW'(pc); lk_pred = MB'(pred);
        #1;
        chk(tag, "hit", 32'(lk_hit), 32'(eh));
        if (eh != 0) begin
            chk(tag, "len", 32'(lk_len), 32'(el));
            chk(tag, "nbr", 32'(lk_nbr), 32'(en));
            chk(tag, "next", 32'(lk_next), 32'(ex));
            chk(tag, "fall", 32'(lk_fall), 32'(ef));
        end
        tick();
    endtask

    initial begin
        m_open = 0;
        for (int i = 0; i < E; i++) mv[i] = 0;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        cmp_en = 1;

        // R1: empty after reset
        probe("R1", 'h0040, 0, 0, 0, 0, 0, 0);
        probe("R1", 'h0100, 3, 0, 0, 0, 0, 0);

        // R4 / R10 / R6: cond taken then return; visible next cycle only
        blk('h0100, 3, 1, 1, 'h0200);
        bb_valid = 1; bb_pc = 'h0200; bb_len = 2; bb_kind = 3; bb_taken = 0; bb_next = 'h0300;
        lk_pc = 'h0100; lk_pred = 3'b011;
        #1;
        chk("R10", "hit in closing cycle", 32'(lk_hit), 0);
        tick();
        probe("R4", 'h0100, 3'b011, 1, 5, 2, 'h0300, 'h0202);
        probe("R7", 'h0100, 3'b111, 1, 5, 2, 'h0300, 'h0202);
        probe("R7", 'h0100, 3'b001, 0, 0, 0, 0, 0);
        probe("R7", 'h0108, 3'b011, 0, 0, 0, 0, 0);

        // R5: straight-line trace at the same index is not stored
        blk('h0108, 4, 1, 0, 'h010C);
        blk('h010C, 4, 0, 0, 'h0110);
        probe("R5", 'h0108, 0, 0, 0, 0, 0, 0);
        probe("R5", 'h0100, 3'b011, 1, 5, 2, 'h0300, 'h0202);

        // R3 / R11: three branches (not taken, jump, taken) close the trace
        blk('h0201, 1, 1, 0, 'h0202);
        blk('h0202, 1, 2, 0, 'h0300);
        blk('h0300, 1, 1, 1, 'h0400);
        probe("R11", 'h0201, 3'b110, 1, 3, 3, 'h0400, 'h0301);
        probe("R7", 'h0201, 3'b010, 0, 0, 0, 0, 0);

        // R8 / R3: next block starts anew and replaces index 0
        blk('h0400, 1, 1, 1, 'h0500);
        blk('h0500, 2, 3, 0, 'h0600);
        probe("R3", 'h0400, 3'b011, 1, 3, 2, 'h0600, 'h0502);
        probe("R8", 'h0100, 3'b011, 0, 0, 0, 0, 0);
        probe("R8", 'h0201, 3'b110, 1, 3, 3, 'h0400, 'h0301);

        // R2 / R11: length overshoot closes; a plain block adds no branch
        blk('h0602, 5, 1, 1, 'h0700);
        blk('h0700, 4, 0, 0, 'h0704);
        probe("R2", 'h0602, 3'b001, 1, 9, 1, 'h0704, 'h0704);

        // R9: flush drops a trace closing in the same cycle
        blk('h0603, 2, 1, 1, 'h0800);
        bb_valid = 1; bb_pc = 'h0800; bb_len = 1; bb_kind = 3; bb_taken = 0; bb_next = 'h0900;
        flush = 1;
        tick();
        probe("R9", 'h0603, 3'b011, 0, 0, 0, 0, 0);
        probe("R9", 'h0201, 3'b110, 0, 0, 0, 0, 0);
        probe("R9", 'h0602, 3'b001, 0, 0, 0, 0, 0);

        // R9: an open trace survives a flush and is stored afterwards
        blk('h0A01, 2, 1, 1, 'h0B00);
        flush = 1;
        tick();
        blk('h0B00, 1, 3, 0, 'h0C00);
        probe("R9", 'h0A01, 3'b011, 1, 3, 2, 'h0C00, 'h0B01);

        // Random phase against the model (R2..R11)
        for (int c = 0; c < 3000; c++) begin
            int r;
            r = $urandom % 8;
            bb_valid = ($urandom % 4) != 0;
            bb_pc    = PCW'('h2000 + ($urandom % 32));
            bb_len   = BLW'(1 + ($urandom % MI));
            bb_kind  = (r < 2) ? 2'd0 : (r < 6) ? 2'd1 : (r == 6) ? 2'd2 : 2'd3;
            bb_taken = 1'($urandom % 2);
            bb_next  = PCW'('h2000 + ($urandom % 32));
            flush    = ($urandom % 64) == 0;
            lk_pc    = PCW'('h2000 + ($urandom % 32));
            lk_pred  = MB'($urandom);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule